// File: doc/BRIEF.md
# Load/Store Alignment and Extension Unit

This unit sits between an execute stage and a data memory organised as 32-bit words. It takes a load or store request made of a base register value, a 16-bit signed displacement, a size code and a signedness flag. From these it forms the effective address and checks that the address is aligned for the access size. For an aligned access it issues one word-aligned memory request with per-lane byte enables. For a store, the request also carries write data with the register's low bytes placed on the enabled lanes.

For a load, the unit keeps the lane position, size and signedness of the pending access. When the memory returns the word, the unit extracts the addressed byte, halfword or word and widens it to 32 bits by sign or zero extension. A static endianness input selects which lanes correspond to which byte addresses. A misaligned access raises a fault flag and produces no memory request. Raising an exception on that fault is left to the surrounding pipeline.

Top module: `lsu_align_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits. `mem_addr` carries that address with its two low bits cleared.
- R2: A byte access is never misaligned. A halfword access is misaligned when address bit 0 is set. A word access is misaligned when either of address bits 1:0 is set. Size code 2'b11 always faults. A faulting access raises `misalign` with `mem_req` low and `mem_be` zero.
- R3: Lane i is `mem_wdata`/`rsp_word` bits 8i+7:8i, and `mem_be[i]` enables it. An aligned access sets exactly the enables of the lanes that hold its bytes: 1, 2 or 4 of them. This applies to loads and stores alike.
- R4: With `big_endian` = 0, the byte at address offset a within a word sits on lane a, and the lowest-addressed byte of a multi-byte item is its least significant. With `big_endian` = 1, the byte at offset a sits on lane 3-a, and the lowest-addressed byte is the most significant.
- R5: A byte store writes only `req_wdata[7:0]`, a halfword store only `req_wdata[15:0]`, and a word store the full value. Lanes that are not enabled are driven zero. `mem_we` is high for stores and low for loads.
- R6: Size codes are 2'b00 byte, 2'b01 halfword and 2'b10 word. A byte or halfword load with `req_unsigned` = 0 is sign-extended; with `req_unsigned` = 1 it is zero-extended. A word load returns the word unchanged, whatever the flag.
- R7: Request outputs (`mem_*`, `misalign`) appear one clock after `req_valid` is sampled. `ld_valid` and `ld_data` appear one clock after `rsp_valid` is sampled. `ld_valid` pulses only when an aligned load is outstanding; a response after a store or a faulted load is ignored.
- R8: While `rst_n` is low, every output is zero and no load is outstanding.
- R9: A cycle with `req_valid` low produces neither `mem_req` nor `misalign` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Lane mapping select, held static outside reset |
| req_valid | input | 1 | Access request strobe |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_unsigned | input | 1 | Zero-extend partial loads |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Register value to store |
| rsp_valid | input | 1 | Memory read word valid |
| rsp_word | input | 32 | Word returned by memory |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Word-aligned address |
| mem_be | output | 4 | Per-lane byte enables |
| mem_wdata | output | 32 | Lane-placed write data |
| misalign | output | 1 | Alignment fault flag |
| ld_valid | output | 1 | Load result strobe |
| ld_data | output | 32 | Extended load result |

## Verification
The corner that is hardest to reach is the interaction of endianness, address offset, size and the sign bit of the extracted item. A fault depends on the effective address after the signed add, not on the base alone. The sweep therefore pairs several bases with displacements that include negative values and a value that crosses a carry, so that every low-address residue appears for every size and for both signedness settings. The load words are built so that the extracted item's top bit is set in some cases and clear in others. After each faulted load and after each completed load, a response is presented with nothing outstanding, to show that it is dropped. The whole sweep is repeated under reset with the opposite endianness.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned LANES    = DATA_W / 8;
    localparam int unsigned LANE_W   = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 16
) (
    input  logic              big_endian,
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  acc_size_e         size,
    output logic [ADDR_W-1:0] word_addr,
    output logic [LANE_W-1:0] lane_base,
    output logic [LANE_W:0]   nbytes,
    output logic              misal
);

    localparam int unsigned EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] ea;
    logic [LANE_W-1:0] low;

    assign ea        = base + {{EXT_W{offset[OFF_W-1]}}, offset};
    assign low       = ea[LANE_W-1:0];
    assign word_addr = {ea[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                nbytes = (LANE_W+1)'(1);
                misal  = 1'b0;
            end
            SZ_HALF: begin
                nbytes = (LANE_W+1)'(2);
                misal  = low[0];
            end
            SZ_WORD: begin
                nbytes = (LANE_W+1)'(LANES);
                misal  = (low != '0);
            end
            default: begin
                nbytes = (LANE_W+1)'(LANES);
                misal  = 1'b1;
            end
        endcase
    end

    // Lowest lane occupied by the item. Big-endian mirrors the item inside
    // the word, so its lowest lane is counted back from the top.
    always_comb begin
        if (big_endian) begin
            lane_base = LANE_W'((LANE_W+1)'(LANES) - nbytes - {1'b0, low});
        end else begin
            lane_base = low;
        end
    end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_pkg::*;
(
    input  logic              enable,
    input  logic [LANE_W-1:0] lane_base,
    input  logic [LANE_W:0]   nbytes,
    input  logic [DATA_W-1:0] src,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] lane_data
);

    logic [LANES-1:0] hit;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W:0]   pos;
        logic [LANE_W:0]   lo;
        logic [LANE_W:0]   hi;
        logic [LANE_W-1:0] idx;

        assign pos    = (LANE_W+1)'(i);
        assign lo     = {1'b0, lane_base};
        assign hi     = lo + nbytes;
        assign idx    = LANE_W'(i) - lane_base;
        assign hit[i] = (pos >= lo) && (pos < hi);
        assign be[i]  = enable && hit[i];

        always_comb begin
            if (hit[i]) begin
                lane_data[i*8 +: 8] = src[idx*8 +: 8];
            end else begin
                lane_data[i*8 +: 8] = 8'h00;
            end
        end
    end

    // The enable count must match the item size computed by address generation.
    always_comb begin
        if (enable) begin
            p_be_width_r3: assert ($countones(be) == int'(nbytes));
        end
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  logic [LANE_W-1:0] lane_base,
    input  acc_size_e         size,
    input  logic              zero_ext,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] aligned;
    logic              fill;

    assign aligned = word >> {lane_base, 3'b000};

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                fill   = !zero_ext && aligned[7];
                result = {{(DATA_W-8){fill}}, aligned[7:0]};
            end
            SZ_HALF: begin
                fill   = !zero_ext && aligned[15];
                result = {{(DATA_W-16){fill}}, aligned[15:0]};
            end
            default: begin
                fill   = 1'b0;
                result = aligned;
            end
        endcase
    end

endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
    import lsu_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_word,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              misalign,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data
);

    typedef struct packed {
        logic              mem_req;
        logic              mem_we;
        logic [ADDR_W-1:0] mem_addr;
        logic [LANES-1:0]  mem_be;
        logic [DATA_W-1:0] mem_wdata;
        logic              fault;
        logic              pend;
        acc_size_e         pend_size;
        logic              pend_zext;
        logic [LANE_W-1:0] pend_lane;
        logic              ld_valid;
        logic [DATA_W-1:0] ld_data;
    } lsu_state_t;

    lsu_state_t st_d, st_q;

    acc_size_e         size_in;
    logic [ADDR_W-1:0] ag_word_addr;
    logic [LANE_W-1:0] ag_lane_base;
    logic [LANE_W:0]   ag_nbytes;
    logic              ag_misal;
    logic [LANES-1:0]  sl_be;
    logic [DATA_W-1:0] sl_data;
    logic [DATA_W-1:0] ex_result;

    assign size_in = acc_size_e'(req_size);

    lsu_agen #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_agen (
        .big_endian (big_endian),
        .base       (req_base),
        .offset     (req_offset),
        .size       (size_in),
        .word_addr  (ag_word_addr),
        .lane_base  (ag_lane_base),
        .nbytes     (ag_nbytes),
        .misal      (ag_misal)
    );

    lsu_store_lanes u_store (
        .enable    (req_valid && !ag_misal),
        .lane_base (ag_lane_base),
        .nbytes    (ag_nbytes),
        .src       (req_wdata),
        .be        (sl_be),
        .lane_data (sl_data)
    );

    lsu_load_extract u_extract (
        .word      (rsp_word),
        .lane_base (st_q.pend_lane),
        .size      (st_q.pend_size),
        .zero_ext  (st_q.pend_zext),
        .result    (ex_result)
    );

    always_comb begin
        st_d           = st_q;
        st_d.mem_req   = 1'b0;
        st_d.mem_we    = 1'b0;
        st_d.mem_be    = '0;
        st_d.mem_wdata = '0;
        st_d.fault     = 1'b0;
        st_d.ld_valid  = 1'b0;

        // A response completes the outstanding load before a new one is logged.
        if (rsp_valid && st_q.pend) begin
            st_d.ld_valid = 1'b1;
            st_d.ld_data  = ex_result;
            st_d.pend     = 1'b0;
        end

        if (req_valid) begin
            if (ag_misal) begin
                st_d.fault = 1'b1;
            end else begin
                st_d.mem_req  = 1'b1;
                st_d.mem_we   = req_store;
                st_d.mem_addr = ag_word_addr;
                st_d.mem_be   = sl_be;
                if (req_store) begin
                    st_d.mem_wdata = sl_data;
                end else begin
                    st_d.pend      = 1'b1;
                    st_d.pend_size = size_in;
                    st_d.pend_zext = req_unsigned;
                    st_d.pend_lane = ag_lane_base;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_req   = st_q.mem_req;
    assign mem_we    = st_q.mem_we;
    assign mem_addr  = st_q.mem_addr;
    assign mem_be    = st_q.mem_be;
    assign mem_wdata = st_q.mem_wdata;
    assign misalign  = st_q.fault;
    assign ld_valid  = st_q.ld_valid;
    assign ld_data   = st_q.ld_data;

    logic [DATA_W-1:0] be_mask;
    for (genvar i = 0; i < LANES; i++) begin : g_mask
        assign be_mask[i*8 +: 8] = {8{mem_be[i]}};
    end

    p_fault_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (mem_be == '0 && !mem_req));

    p_fault_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> $past(req_valid));

    p_word_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[LANE_W-1:0] == '0));

    p_be_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                     || $countones(mem_be) == LANES));

    p_dead_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ((mem_wdata & ~be_mask) == '0));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> (!mem_req && !misalign));

    p_ld_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(rsp_valid));

endmodule

// File: tb/lsu_align_unit_test.sv
`timescale 1ns/1ps
module lsu_align_unit_test;

    localparam int CLK_HALF = 10;
    localparam int MAX_CYC  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_unsigned = 1'b0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_word = '0;
    logic        mem_req, mem_we, misalign, ld_valid;
    logic [31:0] mem_addr, mem_wdata, ld_data;
    logic [3:0]  mem_be;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #CLK_HALF clk = ~clk;

    lsu_align_unit uut (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
        .req_valid(req_valid), .req_store(req_store), .req_size(req_size),
        .req_unsigned(req_unsigned), .req_base(req_base), .req_offset(req_offset),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_word(rsp_word),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .misalign(misalign), .ld_valid(ld_valid),
        .ld_data(ld_data)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    // Byte-by-byte reference: item byte k (k=0 least significant) lives at
    // address ea+k (little) or ea+n-1-k (big); that address picks the lane.
    function automatic int item_lane(input bit bigend, input logic [31:0] ea,
                                     input int n, input int k);
        logic [31:0] a;
        a = ea + 32'(bigend ? (n - 1 - k) : k);
        return bigend ? (3 - int'(a[1:0])) : int'(a[1:0]);
    endfunction

    function automatic int size_bytes(input logic [1:0] sz);
        return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    endfunction

    function automatic bit is_fault(input logic [31:0] ea, input logic [1:0] sz);
        if (sz == 2'b11) return 1'b1;
        return (ea % 32'(size_bytes(sz))) != 0;
    endfunction

    task automatic reset_to(input bit bigend);
        rst_n = 1'b0;
        big_endian = bigend;
        req_valid = 1'b0;
        rsp_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(mem_req == 0 && mem_we == 0 && misalign == 0 && ld_valid == 0 &&
            mem_be == 0 && mem_addr == 0 && mem_wdata == 0 && ld_data == 0,
            "R8 reset outputs", {mem_req, misalign, ld_valid, mem_be}, 32'h0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(mem_req == 0 && misalign == 0, "R9 idle no request",
            {mem_req, misalign}, 32'h0);
    endtask

    task automatic do_store(input logic [31:0] base, input logic [15:0] off,
                            input logic [1:0] sz, input logic [31:0] v, input bit bigend);
        logic [31:0] ea, ewd;
        logic [3:0]  ebe;
        bit f;
        int n;
        ea  = base + {{16{off[15]}}, off};
        n   = size_bytes(sz);
        f   = is_fault(ea, sz);
        ebe = '0;
        ewd = '0;
        if (!f) begin
            for (int k = 0; k < n; k++) begin
                int ln;
                ln = item_lane(bigend, ea, n, k);
                ebe[ln] = 1'b1;
                ewd[ln*8 +: 8] = v[k*8 +: 8];
            end
        end
        req_valid = 1'b1; req_store = 1'b1; req_size = sz; req_unsigned = 1'b0;
        req_base = base; req_offset = off; req_wdata = v;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        chk(misalign == f, "R2 store fault flag", {31'b0, misalign}, {31'b0, f});
        if (f) begin
            chk(mem_req == 0 && mem_be == 0, "R2 faulted store quiet",
                {mem_req, mem_be}, 32'h0);
        end else begin
            chk(mem_req == 1 && mem_we == 1, "R5 store write enable",
                {mem_req, mem_we}, 32'h3);
            chk(mem_addr == (ea & ~32'h3), "R1 store word address", mem_addr, ea & ~32'h3);
            chk(mem_be == ebe, "R3 R4 store byte enables", {28'b0, mem_be}, {28'b0, ebe});
            chk(mem_wdata == ewd, "R4 R5 store lane data", mem_wdata, ewd);
        end
    endtask

    task automatic do_load(input logic [31:0] base, input logic [15:0] off,
                           input logic [1:0] sz, input bit uns, input logic [31:0] w,
                           input bit bigend);
        logic [31:0] ea, ev;
        logic [3:0]  ebe;
        bit f;
        int n;
        ea  = base + {{16{off[15]}}, off};
        n   = size_bytes(sz);
        f   = is_fault(ea, sz);
        ebe = '0;
        ev  = '0;
        if (!f) begin
            for (int k = 0; k < n; k++) begin
                int ln;
                ln = item_lane(bigend, ea, n, k);
                ebe[ln] = 1'b1;
                ev[k*8 +: 8] = w[ln*8 +: 8];
            end
            if (n < 4 && !uns && ev[n*8-1]) begin
                for (int b = n * 8; b < 32; b++) ev[b] = 1'b1;
            end
        end
        req_valid = 1'b1; req_store = 1'b0; req_size = sz; req_unsigned = uns;
        req_base = base; req_offset = off; req_wdata = 32'hDEAD_BEEF;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        chk(misalign == f, "R2 load fault flag", {31'b0, misalign}, {31'b0, f});
        if (!f) begin
            chk(mem_req == 1 && mem_we == 0, "R5 load is read", {mem_req, mem_we}, 32'h2);
            chk(mem_addr == (ea & ~32'h3), "R1 load word address", mem_addr, ea & ~32'h3);
            chk(mem_be == ebe, "R3 load byte enables", {28'b0, mem_be}, {28'b0, ebe});
            rsp_valid = 1'b1;
            rsp_word  = w;
            @(posedge clk);
            #1;
            rsp_valid = 1'b0;
            chk(ld_valid == 1, "R7 load result strobe", {31'b0, ld_valid}, 32'h1);
            chk(ld_data == ev, "R6 load extraction", ld_data, ev);
        end
        // Nothing is outstanding now: a response must be dropped.
        rsp_valid = 1'b1;
        rsp_word  = ~w;
        @(posedge clk);
        #1;
        rsp_valid = 1'b0;
        chk(ld_valid == 0, "R7 stray response ignored", {31'b0, ld_valid}, 32'h0);
    endtask

    initial begin
        logic [31:0] bases [3];
        logic [15:0] offs [8];
        int n;
        bases[0] = 32'h0000_1000;
        bases[1] = 32'h7FFF_FFFE;
        bases[2] = 32'h0001_0003;
        offs[0] = 16'h0000; offs[1] = 16'h0001; offs[2] = 16'h0002;
        offs[3] = 16'h0003; offs[4] = 16'hFFFF; offs[5] = 16'hFFFE;
        offs[6] = 16'h7FFF; offs[7] = 16'h8000;
        n = 0;
        for (int e = 0; e < 2; e++) begin
            reset_to(e[0]);
            for (int bi = 0; bi < 3; bi++) begin
                for (int oi = 0; oi < 8; oi++) begin
                    for (int sz = 0; sz < 4; sz++) begin
                        for (int u = 0; u < 2; u++) begin
                            logic [31:0] v;
                            v = 32'h9C3E_81F7 + 32'(n) * 32'h1357_9BDF;
                            n++;
                            do_store(bases[bi], offs[oi], sz[1:0], v, e[0]);
                            do_load(bases[bi], offs[oi], sz[1:0], u[0], ~v ^ {v[15:0], v[31:16]}, e[0]);
                        end
                    end
                end
            end
            // A quiet cycle after traffic raises nothing.
            @(posedge clk);
            #1;
            chk(mem_req == 0 && misalign == 0, "R9 quiet after traffic",
                {mem_req, misalign}, 32'h0);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", MAX_CYC, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule